// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block is a synchronous controller that burns one byte into a 32K x 8 UV-erasable or one-time-programmable EPROM and then reads it back. A single-cycle command strobe, sampled while the block is idle, latches a 15-bit address and an 8-bit byte. The sequencer then raises the logic-supply enable and, after a rail interval, the programming-supply enable. It drives the address and data buses, lets the setup interval elapse, and applies one timed program pulse. It holds the data, releases the bus, performs a timed verify read, and then powers the rails down in the opposite order.

Every interval is a parameter in nanoseconds. Each is turned into a clock count using the clock period parameter, rounded up and never below one cycle. At the end it produces a one-cycle completion pulse with a pass bit that reports whether the byte read back equals the byte written. Retry loops, supply levels and analog switching are left to the surrounding system.

Top module: `eprom_prog_seq`

## Requirements
- R1: `vpp_en` is never high while `vcc_en` is low. `vcc_en` rises at least ceil(T_RAIL_NS/CLK_NS) cycles before `vpp_en` rises. `vpp_en` falls at least that many cycles before `vcc_en` falls.
- R2: `rom_pgm_n` (active low) is high in the cycle `vpp_en` rises.
- R3: Address, data, `rom_dq_oe`, `rom_ce_n`, `rom_oe_n`, `vcc_en` and `vpp_en` are all unchanged for at least ceil(T_SETUP_NS/CLK_NS) cycles before `rom_pgm_n` falls.
- R4: The program pulse lasts exactly ceil(T_PULSE_NS/CLK_NS) cycles. That is within 95 % to 105 % of T_PULSE_NS. Throughout the pulse, `rom_ce_n` is low, `rom_oe_n` is high, `rom_dq_oe` is high and `vpp_en` is high.
- R5: The data bus stays driven with the written byte for at least ceil(T_DHOLD_NS/CLK_NS) cycles after `rom_pgm_n` rises. The address equals the commanded address until completion.
- R6: `rom_dq_oe` is low whenever `rom_oe_n` is low, and falls at least one cycle before `rom_oe_n` falls. `rom_oe_n` stays low at least ceil(T_RD_VALID_NS/CLK_NS) cycles. `rom_dq_oe` is not raised again until at least ceil(T_FLOAT_NS/CLK_NS) cycles after `rom_oe_n` rises.
- R7: `done` is high for exactly one cycle per accepted command. With it, `pass` is 1 if and only if `rom_dq_in`, sampled in the last cycle of the read window, equals the written byte.
- R8: `busy` is high from the cycle after acceptance through the `done` cycle, and low after it. A `cmd` while `busy` is high is ignored and does not change the address or start another cycle.
- R9: In the cycle after `done`, the outputs are at rest: `vcc_en`=0, `vpp_en`=0, `rom_ce_n`=1, `rom_oe_n`=1, `rom_pgm_n`=1, `rom_dq_oe`=0.
- R10: While and after `rst` is high, the outputs are at the same rest levels, with `busy`=0 and `done`=0.
- R11: A `cmd` held in the first idle cycle after `done` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 1 | Start strobe, sampled while idle |
| cmd_addr | input | 15 | Byte address to program |
| cmd_data | input | 8 | Byte to program |
| rom_addr | output | 15 | Address bus to the EPROM |
| rom_dq_out | output | 8 | Data value driven onto the bus |
| rom_dq_oe | output | 1 | Data bus driver enable |
| rom_dq_in | input | 8 | Data bus as read from the EPROM |
| rom_ce_n | output | 1 | Chip enable, active low |
| rom_oe_n | output | 1 | Output enable, active low |
| rom_pgm_n | output | 1 | Program strobe, active low |
| vcc_en | output | 1 | Enable for the logic supply |
| vpp_en | output | 1 | Enable for the programming supply |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Verify result, valid with `done` |

## Verification
The colliding events are the `done` cycle of one sequence and a new `cmd` strobe. The command must be dropped because the block still counts as busy, yet a strobe one cycle later must start the next byte. The bench raises `cmd` with a different address exactly in the cycle `done` is seen. It checks that `busy` stays low and the address is unchanged, then strobes again in the first idle cycle and expects `busy` on the next cycle. Strobes in the middle of a sequence are judged the same way: only by an unchanged address and a single completion pulse.

// File: rtl/eprom_seq_pkg.sv
`timescale 1ns/1ps
package eprom_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_VCC_UP,
    S_SETUP,
    S_PULSE,
    S_DHOLD,
    S_RELEASE,
    S_READ,
    S_FLOAT,
    S_VPP_DOWN,
    S_DONE
  } seq_state_e;

  typedef struct packed {
    logic vcc_en;
    logic vpp_en;
    logic ce_n;
    logic oe_n;
    logic pgm_n;
    logic dq_oe;
  } pin_set_t;

  localparam pin_set_t PINS_REST = '{vcc_en: 1'b0, vpp_en: 1'b0, ce_n: 1'b1,
                                     oe_n: 1'b1, pgm_n: 1'b1, dq_oe: 1'b0};

  // Round an interval up to whole clock cycles, never fewer than one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eprom_interval_timer.sv
`timescale 1ns/1ps
module eprom_interval_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/eprom_pin_map.sv
`timescale 1ns/1ps
module eprom_pin_map
  import eprom_seq_pkg::*;
(
  input  seq_state_e st,
  output pin_set_t   pins
);

  always_comb begin
    pins = PINS_REST;
    unique case (st)
      S_IDLE, S_DONE: pins = PINS_REST;
      S_VCC_UP: begin
        pins.vcc_en = 1'b1;
      end
      S_SETUP, S_DHOLD: begin
        pins.vcc_en = 1'b1;
        pins.vpp_en = 1'b1;
        pins.ce_n   = 1'b0;
        pins.dq_oe  = 1'b1;
      end
      S_PULSE: begin
        pins.vcc_en = 1'b1;
        pins.vpp_en = 1'b1;
        pins.ce_n   = 1'b0;
        pins.dq_oe  = 1'b1;
        pins.pgm_n  = 1'b0;
      end
      S_RELEASE: begin
        pins.vcc_en = 1'b1;
        pins.vpp_en = 1'b1;
        pins.ce_n   = 1'b0;
      end
      S_READ: begin
        pins.vcc_en = 1'b1;
        pins.vpp_en = 1'b1;
        pins.ce_n   = 1'b0;
        pins.oe_n   = 1'b0;
      end
      S_FLOAT: begin
        pins.vcc_en = 1'b1;
        pins.vpp_en = 1'b1;
      end
      S_VPP_DOWN: begin
        pins.vcc_en = 1'b1;
      end
      default: pins = PINS_REST;
    endcase
  end

endmodule

// File: rtl/eprom_verify_cmp.sv
`timescale 1ns/1ps
module eprom_verify_cmp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] wr_data,
  output logic              match
);

  logic [DATA_W-1:0] diff;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign diff[i] = rd_data[i] ^ wr_data[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match <= 1'b0;
    end else if (capture) begin
      match <= ~|diff;
    end
  end

endmodule

// File: rtl/eprom_seq_fsm.sv
`timescale 1ns/1ps
module eprom_seq_fsm
  import eprom_seq_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned N_RAIL   = 200,
  parameter int unsigned N_SETUP  = 200,
  parameter int unsigned N_PULSE  = 20000,
  parameter int unsigned N_DHOLD  = 200,
  parameter int unsigned N_VALID  = 20,
  parameter int unsigned N_FLOAT  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd,
  input  logic             expired,
  output seq_state_e       state_q,
  output seq_state_e       state_d,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture
);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (cmd)     state_d = S_VCC_UP;
      S_VCC_UP:   if (expired) state_d = S_SETUP;
      S_SETUP:    if (expired) state_d = S_PULSE;
      S_PULSE:    if (expired) state_d = S_DHOLD;
      S_DHOLD:    if (expired) state_d = S_RELEASE;
      S_RELEASE:  if (expired) state_d = S_READ;
      S_READ:     if (expired) state_d = S_FLOAT;
      S_FLOAT:    if (expired) state_d = S_VPP_DOWN;
      S_VPP_DOWN: if (expired) state_d = S_DONE;
      S_DONE:                  state_d = S_IDLE;
      default:                 state_d = S_IDLE;
    endcase
  end

  // Each state lasts exactly its count: load count-1 on entry, leave at zero.
  always_comb begin
    unique case (state_d)
      S_VCC_UP, S_VPP_DOWN: load_val = CNT_W'(N_RAIL - 1);
      S_SETUP:              load_val = CNT_W'(N_SETUP - 1);
      S_PULSE:              load_val = CNT_W'(N_PULSE - 1);
      S_DHOLD:              load_val = CNT_W'(N_DHOLD - 1);
      S_READ:               load_val = CNT_W'(N_VALID - 1);
      S_FLOAT:              load_val = CNT_W'(N_FLOAT - 1);
      default:              load_val = '0;
    endcase
  end

  assign load    = (state_d != state_q);
  assign accept  = (state_q == S_IDLE) && cmd;
  assign capture = (state_q == S_READ) && expired;

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/eprom_prog_seq.sv
`timescale 1ns/1ps
module eprom_prog_seq
  import eprom_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_NS        = 5,
  parameter int unsigned T_RAIL_NS     = 1000,
  parameter int unsigned T_SETUP_NS    = 1000,
  parameter int unsigned T_PULSE_NS    = 100000,
  parameter int unsigned T_DHOLD_NS    = 1000,
  parameter int unsigned T_RD_VALID_NS = 100,
  parameter int unsigned T_FLOAT_NS    = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [DATA_W-1:0] rom_dq_out,
  output logic              rom_dq_oe,
  input  logic [DATA_W-1:0] rom_dq_in,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              rom_pgm_n,
  output logic              vcc_en,
  output logic              vpp_en,
  output logic              busy,
  output logic              done,
  output logic              pass
);

  localparam int unsigned N_RAIL  = ns_to_cycles(T_RAIL_NS, CLK_NS);
  localparam int unsigned N_SETUP = ns_to_cycles(T_SETUP_NS, CLK_NS);
  localparam int unsigned N_PULSE = ns_to_cycles(T_PULSE_NS, CLK_NS);
  localparam int unsigned N_DHOLD = ns_to_cycles(T_DHOLD_NS, CLK_NS);
  localparam int unsigned N_VALID = ns_to_cycles(T_RD_VALID_NS, CLK_NS);
  localparam int unsigned N_FLOAT = ns_to_cycles(T_FLOAT_NS, CLK_NS);
  localparam int unsigned N_MAX   = max_u(max_u(max_u(N_RAIL, N_SETUP), max_u(N_PULSE, N_DHOLD)),
                                          max_u(N_VALID, N_FLOAT));
  localparam int unsigned CNT_W   = $clog2(N_MAX + 1);

  seq_state_e        state_q, state_d;
  logic              load, expired, accept, capture;
  logic [CNT_W-1:0]  load_val;
  pin_set_t          pins_d, pins_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              busy_q, done_q;

  eprom_seq_fsm #(
    .CNT_W(CNT_W), .N_RAIL(N_RAIL), .N_SETUP(N_SETUP), .N_PULSE(N_PULSE),
    .N_DHOLD(N_DHOLD), .N_VALID(N_VALID), .N_FLOAT(N_FLOAT)
  ) u_fsm (
    .clk(clk), .rst(rst), .cmd(cmd), .expired(expired),
    .state_q(state_q), .state_d(state_d), .load(load), .load_val(load_val),
    .accept(accept), .capture(capture)
  );

  eprom_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expired(expired)
  );

  eprom_pin_map u_pins (.st(state_d), .pins(pins_d));

  eprom_verify_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .capture(capture),
    .rd_data(rom_dq_in), .wr_data(data_q), .match(pass)
  );

  // Pins are registered from the next state so they change with the state.
  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= PINS_REST;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      pins_q <= pins_d;
      busy_q <= (state_d != S_IDLE);
      done_q <= (state_d == S_DONE);
      if (accept) begin
        addr_q <= cmd_addr;
        data_q <= cmd_data;
      end
    end
  end

  assign rom_addr   = addr_q;
  assign rom_dq_out = data_q;
  assign rom_dq_oe  = pins_q.dq_oe;
  assign rom_ce_n   = pins_q.ce_n;
  assign rom_oe_n   = pins_q.oe_n;
  assign rom_pgm_n  = pins_q.pgm_n;
  assign vcc_en     = pins_q.vcc_en;
  assign vpp_en     = pins_q.vpp_en;
  assign busy       = busy_q;
  assign done       = done_q;

endmodule

// File: rtl/eprom_prog_seq_chk.sv
`timescale 1ns/1ps
module eprom_prog_seq_chk #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned CLK_NS     = 5,
  parameter int unsigned T_PULSE_NS = 100000
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd,
  input logic              busy,
  input logic              done,
  input logic              vcc_en,
  input logic              vpp_en,
  input logic              rom_ce_n,
  input logic              rom_oe_n,
  input logic              rom_pgm_n,
  input logic              rom_dq_oe,
  input logic [ADDR_W-1:0] rom_addr
);

  localparam int unsigned N_PULSE = (T_PULSE_NS + CLK_NS - 1) / CLK_NS;

  int unsigned low_cnt;

  always_ff @(posedge clk) begin
    if (rst)             low_cnt <= 0;
    else if (!rom_pgm_n) low_cnt <= low_cnt + 1;
    else                 low_cnt <= 0;
  end

  p_vpp_needs_vcc_r1: assert property (@(posedge clk) disable iff (rst)
    vpp_en |-> vcc_en);

  p_pgm_high_at_vpp_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(vpp_en) |-> rom_pgm_n);

  p_pulse_pins_r4: assert property (@(posedge clk) disable iff (rst)
    !rom_pgm_n |-> (!rom_ce_n && rom_oe_n && rom_dq_oe && vpp_en));

  p_pulse_len_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(rom_pgm_n) |-> (low_cnt == N_PULSE));

  p_no_contention_r6: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |-> !rom_dq_oe);

  p_release_first_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rom_oe_n) |-> !$past(rom_dq_oe));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_at_done_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd) |=> $stable(rom_addr));

  p_rest_after_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> (!vcc_en && !vpp_en && rom_ce_n && rom_oe_n && rom_pgm_n && !rom_dq_oe && !busy));

endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
  .ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .T_PULSE_NS(T_PULSE_NS)
) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .busy(busy), .done(done),
  .vcc_en(vcc_en), .vpp_en(vpp_en), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
  .rom_pgm_n(rom_pgm_n), .rom_dq_oe(rom_dq_oe), .rom_addr(rom_addr)
);

// File: tb/tb_eprom_prog_seq.sv
`timescale 1ns/1ps
module tb_eprom_prog_seq;

  localparam int CLK_NS = 5;
  localparam int T_PULSE_NS = 20000;
  localparam int NR = (1000 + CLK_NS - 1) / CLK_NS;
  localparam int NS = (1000 + CLK_NS - 1) / CLK_NS;
  localparam int NP = (T_PULSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int NH = (1000 + CLK_NS - 1) / CLK_NS;
  localparam int NV = (100 + CLK_NS - 1) / CLK_NS;
  localparam int NF = (60 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd = 1'b0;
  logic [14:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic [14:0] rom_addr;
  logic [7:0]  rom_dq_out, rom_dq_in;
  logic rom_dq_oe, rom_ce_n, rom_oe_n, rom_pgm_n, vcc_en, vpp_en, busy, done, pass;

  always #2.5 clk = ~clk;

  eprom_prog_seq #(.CLK_NS(CLK_NS), .T_PULSE_NS(T_PULSE_NS)) dut (
    .clk(clk), .rst(rst), .cmd(cmd), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rom_addr(rom_addr), .rom_dq_out(rom_dq_out), .rom_dq_oe(rom_dq_oe),
    .rom_dq_in(rom_dq_in), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .rom_pgm_n(rom_pgm_n), .vcc_en(vcc_en), .vpp_en(vpp_en),
    .busy(busy), .done(done), .pass(pass)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- EPROM model and timing monitor ----------------
  logic [7:0] mem [0:32767];
  logic [7:0] inject = 8'h00;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [28:0] comp, pv_comp;
  logic pv_vcc, pv_vpp, pv_pgm, pv_oe, pv_dqoe;
  int t_vcc_up, t_vpp_up, t_pgm_dn, t_pgm_up, t_dq_off, t_oe_dn, t_oe_up;
  int t_vpp_dn, t_vcc_dn, t_last_chg, setup_cyc, t_last_oe_up, float_gap;
  int viol_r1, viol_r2, oe_cnt;

  always @(negedge clk) begin
    if (rst) begin
      pv_comp = '0; pv_vcc = 0; pv_vpp = 0; pv_pgm = 1; pv_oe = 1; pv_dqoe = 0;
      t_last_oe_up = -1; float_gap = -1; viol_r1 = 0; viol_r2 = 0; oe_cnt = 0;
      t_last_chg = 0; setup_cyc = 0;
      rom_dq_in = 8'h00;
    end else begin
      comp = {rom_addr, rom_dq_out, rom_dq_oe, rom_ce_n, rom_oe_n, vpp_en, vcc_en};
      if (comp != pv_comp) t_last_chg = cyc;
      if (vpp_en && !vcc_en) viol_r1++;
      if (vpp_en && !pv_vpp && !rom_pgm_n) viol_r2++;
      if (vcc_en && !pv_vcc) t_vcc_up = cyc;
      if (!vcc_en && pv_vcc) t_vcc_dn = cyc;
      if (vpp_en && !pv_vpp) t_vpp_up = cyc;
      if (!vpp_en && pv_vpp) t_vpp_dn = cyc;
      if (!rom_pgm_n && pv_pgm) begin t_pgm_dn = cyc; setup_cyc = cyc - t_last_chg; end
      if (rom_pgm_n && !pv_pgm) begin
        t_pgm_up = cyc;
        if (!rom_ce_n && vpp_en && rom_dq_oe) mem[rom_addr] = mem[rom_addr] & rom_dq_out;
      end
      if (!rom_dq_oe && pv_dqoe) t_dq_off = cyc;
      if (rom_dq_oe && !pv_dqoe && t_last_oe_up >= 0) float_gap = cyc - t_last_oe_up;
      if (!rom_oe_n && pv_oe) t_oe_dn = cyc;
      if (rom_oe_n && !pv_oe) begin t_oe_up = cyc; t_last_oe_up = cyc; end
      if (!rom_ce_n && !rom_oe_n) oe_cnt++; else oe_cnt = 0;
      // Data is only valid once the access time has elapsed with OE low.
      rom_dq_in = (oe_cnt >= NV) ? (mem[rom_addr] ^ inject) : ~(mem[rom_addr] ^ inject);
      pv_comp = comp; pv_vcc = vcc_en; pv_vpp = vpp_en; pv_pgm = rom_pgm_n;
      pv_oe = rom_oe_n; pv_dqoe = rom_dq_oe;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic bit rest_ok();
    return !vcc_en && !vpp_en && rom_ce_n && rom_oe_n && rom_pgm_n && !rom_dq_oe;
  endfunction

  // mode 0: plain, 1: strobe while busy, 2: strobe in the done cycle
  task automatic do_op(input logic [14:0] a, input logic [7:0] d,
                       input logic [7:0] inj, input int mode);
    logic exp_pass;
    exp_pass = (((mem[a] & d) ^ inj) == d);
    inject = inj;
    while (busy) step();
    cmd_addr = a; cmd_data = d; cmd = 1'b1;
    step();
    cmd = 1'b0;
    check(busy == 1'b1, "R8 busy after accept", busy, 1);
    if (mode == 1) begin
      repeat (60) step();
      cmd_addr = ~a; cmd_data = ~d; cmd = 1'b1;
      step();
      cmd = 1'b0;
    end
    while (!done) step();
    check(pass == exp_pass, "R7 verify result", pass, exp_pass);
    check(busy == 1'b1, "R8 busy in done cycle", busy, 1);
    check(rom_addr == a, "R5 R8 address kept", rom_addr, a);
    check(t_vpp_up - t_vcc_up >= NR, "R1 rail up order", t_vpp_up - t_vcc_up, NR);
    check(t_vcc_dn - t_vpp_dn >= NR, "R1 rail down order", t_vcc_dn - t_vpp_dn, NR);
    check(viol_r1 == 0, "R1 vpp without vcc", viol_r1, 0);
    check(viol_r2 == 0, "R2 pgm high at vpp", viol_r2, 0);
    check(setup_cyc >= NS, "R3 setup", setup_cyc, NS);
    check(t_pgm_up - t_pgm_dn == NP, "R4 pulse length", t_pgm_up - t_pgm_dn, NP);
    check((t_pgm_up - t_pgm_dn) * CLK_NS * 100 >= T_PULSE_NS * 95 &&
          (t_pgm_up - t_pgm_dn) * CLK_NS * 100 <= T_PULSE_NS * 105,
          "R4 pulse window", (t_pgm_up - t_pgm_dn) * CLK_NS, T_PULSE_NS);
    check(t_dq_off - t_pgm_up >= NH, "R5 data hold", t_dq_off - t_pgm_up, NH);
    check(t_oe_dn > t_dq_off, "R6 release before OE", t_oe_dn, t_dq_off + 1);
    check(t_oe_up - t_oe_dn >= NV, "R6 read window", t_oe_up - t_oe_dn, NV);
    if (float_gap >= 0)
      check(float_gap >= NF, "R6 float gap", float_gap, NF);
    if (mode == 2) cmd_addr = a ^ 15'h1;
    if (mode == 2) cmd = 1'b1;
    step();
    cmd = 1'b0;
    check(done == 1'b0, "R7 done one cycle", done, 0);
    check(rest_ok(), "R9 rest after done",
          {vcc_en, vpp_en, rom_ce_n, rom_oe_n, rom_pgm_n, rom_dq_oe}, 6'b001110);
    check(busy == 1'b0, "R8 busy low after done", busy, 0);
    if (mode == 2) check(rom_addr == a, "R8 done-cycle strobe ignored", rom_addr, a);
  endtask

  initial begin
    for (int i = 0; i < 32768; i++) mem[i] = 8'hFF;
    void'($urandom(32'h5EED));
    repeat (4) step();
    check(rest_ok() && !busy && !done, "R10 rest during reset",
          {busy, done, vcc_en, vpp_en, rom_ce_n, rom_oe_n, rom_pgm_n, rom_dq_oe}, 8'b00001110);
    rst = 1'b0;
    step();
    check(rest_ok() && !busy && !done, "R10 rest after reset",
          {busy, done, vcc_en, vpp_en, rom_ce_n, rom_oe_n, rom_pgm_n, rom_dq_oe}, 8'b00001110);

    do_op(15'h0000, 8'hA5, 8'h00, 0);       // erased byte: pass
    do_op(15'h7FFF, 8'h00, 8'h00, 1);       // top address, all zeros, busy strobe
    do_op(15'h0000, 8'hFF, 8'h00, 2);       // bits cannot return to 1: fail
    // R11: the next strobe lands in the first idle cycle after done
    do_op(15'h0123, 8'h3C, 8'h00, 0);
    do_op(15'h0124, 8'h81, 8'h10, 0);       // stuck bit on read: fail
    for (int k = 0; k < 12; k++) begin
      logic [14:0] a;
      logic [7:0]  d;
      logic [7:0]  inj;
      a   = 15'($urandom % 8) | 15'h0040;
      d   = 8'($urandom);
      inj = ($urandom % 5 == 0) ? 8'h04 : 8'h00;
      do_op(a, d, inj, int'($urandom % 3));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule